// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block derives a serial-channel timing strobe from a reference clock. Software writes one control word over a simple write port. The word carries the enable, an optional divide-by-16 prescale stage and a 12-bit divisor. The output is a one-cycle strobe in the reference clock domain. It repeats at sixteen times the wanted bit rate, so a receiver that oversamples 16x can use it as its sample clock enable.

The divisor is written as the wanted ratio minus one. A value N gives one output period for every N+1 clocks into the counter. The counter clock is either the reference clock itself or the reference clock after the prescale stage. The prescale stage covers slow rates whose ratio does not fit in 12 bits. A divisor written while the generator runs is taken at the next counter reload, so the period in progress always finishes. Clearing the enable holds the counter and prescaler at zero and keeps the output low. Several copies of this block can sit side by side, each feeding whichever channel the system routes it to.

Top module: `baud_gen`

## Requirements
- R1: After reset the generator is disabled and `baud_tick_o` is 0.
- R2: Control word layout: bit 14 is the enable, bit 13 selects the divide-by-16 prescale stage, and bits 12:1 hold the divisor N. Bits 0 and 15 are ignored. A write takes effect on the clock edge where `wr_en_i` is 1.
- R3: With the prescaler off, `baud_tick_o` is high for one reference cycle in every N+1. For N = 0 it stays high on every cycle.
- R4: With the prescaler on, `baud_tick_o` is high for one reference cycle in every 16*(N+1). Two strobes are never adjacent.
- R5: A write that sets the enable on a disabled generator at clock edge E gives the first strobe in the cycle after edge E+1 if the prescaler is off, and after edge E+16 if it is on. The output stays low in the cycle right after E.
- R6: A divisor written while the generator runs is taken at the next reload. The current period completes at its old length, and the periods after it use the new value.
- R7: While the enable is 0 the output is low from the second cycle after the disabling edge onward, and the counter and prescaler are cleared. A later re-enable restarts with the latency of R5.
- R8: The whole divisor range from 0 to 4095 works, with the prescaler both on and off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word (enable, prescale select, divisor) |
| baud_tick_o | output | 1 | One-cycle strobe at the generated rate |

## Verification
The hardest case to reach from the ports is a divisor change that lands in the middle of a running period. The write has to arrive a few cycles after a strobe and well before the next reload. The bench first lines itself up on an observed strobe. It then writes the new divisor a fixed number of cycles later and measures the interval to the next strobe and the one after it. The longest intervals, divisor 4095 with the prescaler on, are measured once only to keep the run short. The rest of the run mixes random small divisors with these directed cases.

// File: rtl/bg_pkg.sv
package bg_pkg;
   // Default geometry of the generator
   localparam int BG_DIV_W     = 12;  // divisor counter width
   localparam int BG_DIV_LSB   = 1;   // divisor field starts here
   localparam int BG_PRE_LOG2  = 4;   // prescale ratio is 2**BG_PRE_LOG2
   localparam int BG_WORD_W    = 16;  // control word width

   // Position of the top control bit (enable) for a given geometry
   function automatic int bg_en_bit(input int div_lsb, input int div_w);
      return div_lsb + div_w + 1;
   endfunction
endpackage

// File: rtl/bg_ctrl_reg.sv
module bg_ctrl_reg #(
   parameter int WORD_W  = bg_pkg::BG_WORD_W,
   parameter int DIV_W   = bg_pkg::BG_DIV_W,
   parameter int DIV_LSB = bg_pkg::BG_DIV_LSB
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic              en_o,
   output logic              pre_o,
   output logic [DIV_W-1:0]  div_o
);
   localparam int PRE_BIT = DIV_LSB + DIV_W;
   localparam int EN_BIT  = bg_pkg::bg_en_bit(DIV_LSB, DIV_W);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o  <= 1'b0;
         pre_o <= 1'b0;
         div_o <= '0;
      end else if (wr_en_i) begin
         en_o  <= wr_data_i[EN_BIT];
         pre_o <= wr_data_i[PRE_BIT];
         div_o <= wr_data_i[PRE_BIT-1:DIV_LSB];
      end
   end

   // Bits outside the defined fields are accepted and dropped
   logic unused_lo;
   assign unused_lo = ^wr_data_i[DIV_LSB-1:0];
   generate
      if (WORD_W > EN_BIT + 1) begin : g_hi_pad
         logic unused_hi;
         assign unused_hi = ^wr_data_i[WORD_W-1:EN_BIT+1];
      end
   endgenerate
endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
   parameter int PRE_LOG2 = bg_pkg::BG_PRE_LOG2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic use_i,
   output logic step_o
);
   generate
      if (PRE_LOG2 > 0) begin : g_pre
         logic [PRE_LOG2-1:0] pcnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pcnt_q <= '0;
            end else if (!run_i || !use_i) begin
               pcnt_q <= '0;
            end else begin
               pcnt_q <= pcnt_q + 1'b1;
            end
         end
         assign step_o = use_i ? (&pcnt_q) : 1'b1;
      end else begin : g_no_pre
         logic unused_sel;
         assign unused_sel = use_i ^ run_i ^ clk_i ^ rst_ni;
         assign step_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
   parameter int DIV_W = bg_pkg::BG_DIV_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             step_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             strobe_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         strobe_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q    <= '0;
         strobe_o <= 1'b0;
      end else if (step_i) begin
         strobe_o <= at_zero;
         if (at_zero) begin
            cnt_q <= div_i;   // divisor sampled only at reload
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else begin
         strobe_o <= 1'b0;
      end
   end
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
   parameter int WORD_W   = bg_pkg::BG_WORD_W,
   parameter int DIV_W    = bg_pkg::BG_DIV_W,
   parameter int DIV_LSB  = bg_pkg::BG_DIV_LSB,
   parameter int PRE_LOG2 = bg_pkg::BG_PRE_LOG2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic              baud_tick_o
);
   localparam int EN_BIT = bg_pkg::bg_en_bit(DIV_LSB, DIV_W);

   initial begin
      assert (DIV_W >= 1);
      assert (DIV_LSB >= 1);
      assert (WORD_W >= EN_BIT + 1);
      assert (PRE_LOG2 >= 0 && PRE_LOG2 <= 8);
   end

   logic             ctrl_en;
   logic             ctrl_pre;
   logic [DIV_W-1:0] ctrl_div;
   logic             pre_step;

   bg_ctrl_reg #(.WORD_W(WORD_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB)) i_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .en_o      (ctrl_en),
      .pre_o     (ctrl_pre),
      .div_o     (ctrl_div)
   );

   bg_prescale #(.PRE_LOG2(PRE_LOG2)) i_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ctrl_en),
      .use_i  (ctrl_pre),
      .step_o (pre_step)
   );

   bg_divider #(.DIV_W(DIV_W)) i_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (ctrl_en),
      .step_i   (pre_step),
      .div_i    (ctrl_div),
      .strobe_o (baud_tick_o)
   );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 12,
   parameter int EN_BIT = 14
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [WORD_W-1:0] wr_data_i,
   input logic              tick_i,
   input logic              ctrl_en_i,
   input logic              ctrl_pre_i,
   input logic [DIV_W-1:0]  ctrl_div_i
);
   AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_en_i |=> !tick_i); // R7

   AST_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_en_i && wr_en_i && wr_data_i[EN_BIT]) |=> !tick_i); // R5

   AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && ctrl_pre_i) |=> !tick_i); // R4

   AST_NO_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && ($past(ctrl_div_i) != '0)) |=> !tick_i); // R3
endmodule

bind baud_gen baud_gen_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W), .EN_BIT(EN_BIT)) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_en_i    (wr_en_i),
   .wr_data_i  (wr_data_i),
   .tick_i     (baud_tick_o),
   .ctrl_en_i  (ctrl_en),
   .ctrl_pre_i (ctrl_pre),
   .ctrl_div_i (ctrl_div)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        tick;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   baud_gen i_baud_gen (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .wr_en_i     (wr_en),
      .wr_data_i   (wr_data),
      .baud_tick_o (tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // Reference: R3/R4 period and R5 latency (counted in sampled negedges)
   function automatic int exp_period(input int n, input bit pre);
      return (pre ? 16 : 1) * (n + 1);
   endfunction
   function automatic int exp_latency(input bit pre);
      return pre ? 17 : 2;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R2 layout: [15]=ignored, [14]=enable, [13]=prescale, [12:1]=N, [0]=ignored
   task automatic write_cfg(input int n, input bit pre, input bit en, input bit junk);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = {junk, en, pre, n[11:0], junk};
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   // Counts negedges until tick seen, starting at count 'start'
   task automatic wait_tick(input int start, input int limit, output int cnt);
      cnt = start;
      while (!tick && cnt < limit) begin
         @(negedge clk);
         cnt++;
      end
      if (!tick) cnt = -1;
   endtask

   task automatic next_period(input int limit, output int cnt);
      @(negedge clk);
      wait_tick(1, limit, cnt);
   endtask

   task automatic run_case(input string req, input int n, input bit pre, input bit junk);
      int c;
      write_cfg(n, pre, 1'b1, junk);
      wait_tick(1, 80, c);
      check({req, " latency"}, c, exp_latency(pre));
      next_period(70000, c);
      check({req, " period"}, c, exp_period(n, pre));
   endtask

   initial begin
      int c;
      int lows;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 tick in reset", tick, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 tick after reset", tick, 0);

      // R2/R7 enable bit clear keeps output low
      write_cfg(3, 1'b0, 1'b0, 1'b1);
      lows = 0;
      repeat (50) begin
         @(negedge clk);
         if (!tick) lows++;
      end
      check("R7 disabled output low", lows, 50);

      // R3/R5/R8 N=0 no prescale: constant high
      run_case("R3 N=0", 0, 1'b0, 1'b0);
      @(negedge clk);
      check("R3 N=0 stays high", tick, 1);
      write_cfg(0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);

      // R8 full range, prescaler off
      run_case("R8 N=4095", 4095, 1'b0, 1'b0);
      write_cfg(0, 1'b0, 1'b0, 1'b0);

      // R4/R5 prescaled N=0
      run_case("R4 N=0 pre", 0, 1'b1, 1'b0);
      write_cfg(0, 1'b0, 1'b0, 1'b0);

      // R4/R8 prescaled N=4095
      run_case("R8 N=4095 pre", 4095, 1'b1, 1'b0);
      write_cfg(0, 1'b0, 1'b0, 1'b0);

      // R2 ignored bits set
      run_case("R2 junk bits", 5, 1'b0, 1'b1);
      next_period(100, c);
      check("R2 junk bits second period", c, exp_period(5, 1'b0));
      write_cfg(0, 1'b0, 1'b0, 1'b0);

      // R6 divisor change mid-period
      run_case("R6 setup", 20, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      write_cfg(2, 1'b0, 1'b1, 1'b0);     // lands 4 cycles after the strobe
      wait_tick(5, 100, c);
      check("R6 old period completes", c, exp_period(20, 1'b0));
      next_period(100, c);
      check("R6 new period", c, exp_period(2, 1'b0));

      // R7 disable mid-run, then restart
      write_cfg(2, 1'b0, 1'b0, 1'b0);
      lows = 0;
      repeat (30) begin
         @(negedge clk);
         if (!tick) lows++;
      end
      check("R7 low after disable", lows, 30);
      run_case("R7 restart", 7, 1'b1, 1'b0);
      write_cfg(0, 1'b0, 1'b0, 1'b0);

      // R3/R4 random divisors and prescale choice
      for (int i = 0; i < 8; i++) begin
         int rn;
         bit rp;
         bit rj;
         rn = int'($urandom_range(63, 0));
         rp = 1'($urandom_range(1, 0));
         rj = 1'($urandom_range(1, 0));
         run_case(rp ? "R4 random" : "R3 random", rn, rp, rj);
         next_period(2000, c);
         check(rp ? "R4 random second" : "R3 random second", c, exp_period(rn, rp));
         write_cfg(0, 1'b0, 1'b0, 1'b0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule